// File: doc/BRIEF.md
# Prioritized Range-Rule Address Decoder

This block is a purely combinational decoder that turns a request address into the index of an output port. It does this by checking the address against a rule table supplied at run time. Each rule carries a target port, a lower bound and an upper bound. The lower bound is inclusive and the upper bound is exclusive. When more than one rule covers the address, the rule stored at the highest table position decides the target.

A requester that hits no rule can be steered to a fallback port. It gets that port if its default-enable input is set. Otherwise the decoder raises a decode-error flag so the surrounding fabric can answer the request itself.

The rule table and the fallback settings are ordinary inputs. The instantiating logic may rewrite them between requests.

Top module: `addrRuleDecoder`

## Requirements
- R1: An address selects rule k only when `ruleStart[k] <= addrIn` and `addrIn < ruleEnd[k]`. An address equal to the end bound does not select that rule.
- R2: When several rules contain the address, `portIdx` takes the port of the rule with the largest table index.
- R3: A rule whose start equals its end contains no address.
- R4: Different rules may name the same port, and each of them routes to that port.
- R5: With no rule hit and `defaultEn` = 1, `portIdx` equals `defaultPort`, `matchOut` = 0 and `decErrOut` = 0.
- R6: With no rule hit and `defaultEn` = 0, `decErrOut` = 1 and `matchOut` = 0. In this case `portIdx` carries no meaning.
- R7: `matchOut` and `decErrOut` are never 1 together. Whenever a rule hits, `matchOut` = 1 and `decErrOut` = 0, whatever `defaultEn` is.
- R8: A change to the rule table or to the fallback inputs changes the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addrIn | input | AddrW | Address to decode |
| ruleStart | input | AddrW x NumRules | Inclusive lower bound of each rule |
| ruleEnd | input | AddrW x NumRules | Exclusive upper bound of each rule |
| rulePort | input | IdxW x NumRules | Target port of each rule |
| defaultEn | input | 1 | Enables fallback for unmatched addresses |
| defaultPort | input | IdxW | Fallback port index |
| portIdx | output | IdxW | Selected port |
| matchOut | output | 1 | A rule contains the address |
| decErrOut | output | 1 | No rule hit and no fallback enabled |

## Verification
The bench places addresses exactly at a start bound, one below an end bound and exactly at an end bound. An off-by-one compare would show up there as a wrongly accepted or wrongly rejected address. It stacks overlapping rules whose ports differ, so a decoder that lets the lowest index win reports the wrong port. It also loads zero-length rules, which an inclusive end compare would wrongly hit. Finally, it toggles the fallback enable around unmatched addresses and hits with the enable set, which exposes an error flag that ignores the fallback or a fallback that overrides a real hit.

// File: rtl/addrDecPkg.sv
package addrDecPkg;

  // Strobes from the priority control to the output stage
  typedef struct packed {
    logic anyHit;
    logic takeDefault;
    logic raiseErr;
  } decStrobe_t;

  function automatic int widthMin1(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/ruleMatchDp.sv
module ruleMatchDp #(
  parameter int NumRules = 4,
  parameter int AddrW    = 16
) (
  input  logic [AddrW-1:0]    addrIn,
  input  logic [AddrW-1:0]    ruleStart [NumRules],
  input  logic [AddrW-1:0]    ruleEnd   [NumRules],
  output logic [NumRules-1:0] ruleHit
);

  for (genvar k = 0; k < NumRules; k++) begin : gRule
    logic aboveStart;
    logic belowEnd;
    assign aboveStart = (addrIn >= ruleStart[k]);
    assign belowEnd   = (addrIn <  ruleEnd[k]);
    assign ruleHit[k] = aboveStart && belowEnd;

    always_comb begin
      // R3
      empty_rule_chk: assert (!(ruleHit[k] && (ruleStart[k] == ruleEnd[k])))
        else $error("zero-length rule %0d hit", k);
    end
  end

endmodule

// File: rtl/prioCtrl.sv
module prioCtrl
  import addrDecPkg::*;
#(
  parameter int NumRules = 4,
  parameter int RuleIdxW = 2
) (
  input  logic [NumRules-1:0] ruleHit,
  input  logic                defaultEn,
  output decStrobe_t          strobe,
  output logic [RuleIdxW-1:0] winner
);

  always_comb begin
    winner = '0;
    for (int i = 0; i < NumRules; i++) begin
      if (ruleHit[i]) winner = RuleIdxW'(i);
    end
  end

  always_comb begin
    strobe.anyHit      = |ruleHit;
    strobe.takeDefault = !strobe.anyHit && defaultEn;
    strobe.raiseErr    = !strobe.anyHit && !defaultEn;
  end

  always_comb begin
    for (int j = 0; j < NumRules; j++) begin
      // R2
      highest_wins_chk: assert (!(strobe.anyHit && (j > int'(winner)) && ruleHit[j]))
        else $error("rule %0d above winner also hit", j);
    end
    // R6
    err_needs_miss_chk: assert (!(strobe.raiseErr && ((|ruleHit) || defaultEn)))
      else $error("error raised with hit or fallback");
  end

endmodule

// File: rtl/addrRuleDecoder.sv
module addrRuleDecoder
  import addrDecPkg::*;
#(
  parameter int NumRules = 4,
  parameter int NumPorts = 5,
  parameter int AddrW    = 16,
  localparam int IdxW     = widthMin1(NumPorts),
  localparam int RuleIdxW = widthMin1(NumRules)
) (
  input  logic [AddrW-1:0] addrIn,
  input  logic [AddrW-1:0] ruleStart [NumRules],
  input  logic [AddrW-1:0] ruleEnd   [NumRules],
  input  logic [IdxW-1:0]  rulePort  [NumRules],
  input  logic             defaultEn,
  input  logic [IdxW-1:0]  defaultPort,
  output logic [IdxW-1:0]  portIdx,
  output logic             matchOut,
  output logic             decErrOut
);

  logic [NumRules-1:0] ruleHit;
  logic [RuleIdxW-1:0] winner;
  decStrobe_t          strobe;

  ruleMatchDp #(.NumRules(NumRules), .AddrW(AddrW)) uDp (
    .addrIn   (addrIn),
    .ruleStart(ruleStart),
    .ruleEnd  (ruleEnd),
    .ruleHit  (ruleHit)
  );

  prioCtrl #(.NumRules(NumRules), .RuleIdxW(RuleIdxW)) uCtrl (
    .ruleHit  (ruleHit),
    .defaultEn(defaultEn),
    .strobe   (strobe),
    .winner   (winner)
  );

  assign portIdx   = strobe.anyHit ? rulePort[winner] : defaultPort;
  assign matchOut  = strobe.anyHit;
  assign decErrOut = strobe.raiseErr;

  always_comb begin
    // R7
    match_err_excl_chk: assert (!(matchOut && decErrOut))
      else $error("match and error both set");
    // R1
    winner_covers_chk: assert (!matchOut ||
        ((addrIn >= ruleStart[winner]) && (addrIn < ruleEnd[winner])))
      else $error("winning rule does not contain address");
    // R5
    default_route_chk: assert (!(strobe.takeDefault && (portIdx != defaultPort || decErrOut)))
      else $error("fallback not applied");
  end

endmodule

// File: tb/addrRuleDecoder_test.sv
module addrRuleDecoder_test;
  localparam int ClkPeriod = 10;
  localparam int NumRules  = 4;
  localparam int NumPorts  = 5;
  localparam int AddrW     = 16;
  localparam int IdxW      = 3;

  logic clk = 0;
  always #(ClkPeriod/2) clk = ~clk;

  logic [AddrW-1:0] addrIn;
  logic [AddrW-1:0] ruleStart [NumRules];
  logic [AddrW-1:0] ruleEnd   [NumRules];
  logic [IdxW-1:0]  rulePort  [NumRules];
  logic             defaultEn;
  logic [IdxW-1:0]  defaultPort;
  logic [IdxW-1:0]  portIdx;
  logic             matchOut, decErrOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  addrRuleDecoder #(.NumRules(NumRules), .NumPorts(NumPorts), .AddrW(AddrW)) uut (
    .addrIn(addrIn), .ruleStart(ruleStart), .ruleEnd(ruleEnd), .rulePort(rulePort),
    .defaultEn(defaultEn), .defaultPort(defaultPort),
    .portIdx(portIdx), .matchOut(matchOut), .decErrOut(decErrOut)
  );

  // Reference model: returns {err, match, port}
  function automatic logic [IdxW+1:0] refDecode();
    logic hit = 0;
    logic [IdxW-1:0] p = defaultPort;
    for (int k = 0; k < NumRules; k++)
      if (addrIn >= ruleStart[k] && addrIn < ruleEnd[k]) begin
        hit = 1;
        p = rulePort[k];
      end
    return {(!hit && !defaultEn), hit, p};
  endfunction

  task automatic checkNow(input string tag);
    logic [IdxW+1:0] e;
    @(negedge clk);
    e = refDecode();
    checks++;
    if (matchOut !== e[IdxW] || decErrOut !== e[IdxW+1] ||
        (!e[IdxW+1] && portIdx !== e[IdxW-1:0])) begin
      fails++;
      $display("FAIL %s addr=%0h got port=%0d m=%0b e=%0b exp port=%0d m=%0b e=%0b",
               tag, addrIn, portIdx, matchOut, decErrOut, e[IdxW-1:0], e[IdxW], e[IdxW+1]);
    end
  endtask

  task automatic setRule(input int k, input int s, input int e, input int p);
    ruleStart[k] = AddrW'(s);
    ruleEnd[k]   = AddrW'(e);
    rulePort[k]  = IdxW'(p);
  endtask

  task automatic expectFixed(input string tag, input int ep, input bit em, input bit ee);
    @(negedge clk);
    checks++;
    if (matchOut !== em || decErrOut !== ee || (!ee && portIdx !== IdxW'(ep))) begin
      fails++;
      $display("FAIL %s got port=%0d m=%0b e=%0b exp port=%0d m=%0b e=%0b",
               tag, portIdx, matchOut, decErrOut, ep, em, ee);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    addrIn = '0; defaultEn = 0; defaultPort = '0;
    for (int k = 0; k < NumRules; k++) setRule(k, 0, 0, 0);
    // all-empty table, no fallback -> error (R3, R6)
    expectFixed("R3_R6 empty table", 0, 0, 1);

    @(posedge clk);
    setRule(0, 'h100, 'h200, 1);
    setRule(1, 'h180, 'h1c0, 2);
    setRule(2, 'h300, 'h300, 3);
    setRule(3, 'h400, 'h480, 1);
    addrIn = 'h100; expectFixed("R1 at start", 1, 1, 0);
    addrIn = 'h1ff; expectFixed("R1 end-1", 1, 1, 0);
    addrIn = 'h200; expectFixed("R1 at end", 0, 0, 1);
    addrIn = 'h0ff; expectFixed("R1 below start", 0, 0, 1);
    addrIn = 'h180; expectFixed("R2 overlap", 2, 1, 0);
    addrIn = 'h1bf; expectFixed("R2 overlap top", 2, 1, 0);
    addrIn = 'h1c0; expectFixed("R2 past inner", 1, 1, 0);
    addrIn = 'h300; expectFixed("R3 zero-length", 0, 0, 1);
    addrIn = 'h440; expectFixed("R4 shared port", 1, 1, 0);
    defaultEn = 1; defaultPort = 4;
    addrIn = 'h300; expectFixed("R5 fallback", 4, 0, 0);
    addrIn = 'h150; expectFixed("R7 hit beats fallback", 1, 1, 0);
    defaultEn = 0;
    addrIn = 'h500; expectFixed("R6 no fallback", 0, 0, 1);
    setRule(2, 'h4f0, 'h510, 3);
    expectFixed("R8 table rewrite", 3, 1, 0);

    for (int n = 0; n < 400; n++) begin
      @(posedge clk);
      for (int k = 0; k < NumRules; k++) begin
        int s = int'($urandom_range(0, 255));
        setRule(k, s, s + int'($urandom_range(0, 48)), int'($urandom_range(0, NumPorts-1)));
      end
      defaultEn   = 1'($urandom_range(0, 1));
      defaultPort = IdxW'($urandom_range(0, NumPorts-1));
      addrIn      = AddrW'($urandom_range(0, 320));
      checkNow("R1_R2_R5_R6_R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(ClkPeriod*100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule